// File: doc/BRIEF.md
# DMA Group Control Block

This block is the shared control point for a group of DMA channels. Software reaches it through a simple register bus. One bus region holds a few global registers. The region below it is split into equal 32-byte windows, one per channel. Accesses that land in a channel window are decoded to a one-hot select, a byte offset and a read-data mux. The channel register files themselves sit outside this block.

The global side has several parts:
- A control word holding the controller enable, a fast-mode bit and two sticky summary flags, one for bus faults and one for halts.
- A per-channel pending word whose bits are ORed onto one interrupt line.
- A write-to-set doorbell that launches a channel's descriptor fetch.
- A read-only view of which channels have a fetch in flight.
- A mask that marks channels as programmable.

Each channel reports three single-cycle event inputs: done, halt and bus-fault.

A three-state machine gates the doorbell and the interrupt:
- `ST_OFF`: the controller is disabled.
- `ST_RUN`: the controller is enabled and both flags are clear.
- `ST_STALL`: the controller is enabled and at least one flag is set.

Its transitions are:
- T_ENABLE: `ST_OFF` to `ST_RUN`, when enable is written with no flag set.
- T_ENABLE_STALLED: `ST_OFF` to `ST_STALL`, when enable is written while a flag is set.
- T_FAULT: `ST_RUN` to `ST_STALL`, when a halt or bus-fault event arrives.
- T_RECOVER: `ST_STALL` to `ST_RUN`, when software clears both flags.
- T_DISABLE: any state to `ST_OFF`, when enable is written to zero.

Top module: `dma_glb_ctrl`

## Requirements
- R1: After reset, the following all read as zero or are low: control word, pending word, in-flight word, programmable mask, `irq`, `fetch_start` and `fast_mode`.
- R2: The control word is at global offset 0x00. Bit 0 is the enable and bit 31 is fast mode (it drives `fast_mode`). Both are written directly. Bit 2 (bus-fault flag) and bit 3 (halt flag) can never be set by a software write.
- R3: Any event of channel n sets pending bit n.
  - A halt event also sets control bit 3.
  - A bus-fault event also sets control bit 2.
  - A done event sets no flag.
  - Any event of channel n clears in-flight bit n.
- R4: A control write with bit 2 or bit 3 at zero clears that flag. A one in that position leaves the flag as it was.
- R5: A write of one to bit n at offset 0x0C sets in-flight bit n (offset 0x08). It also raises `fetch_start[n]` for exactly the cycle after the write. Offset 0x0C reads as zero.
- R6: A doorbell write has no effect on `fetch_start` or the in-flight word while the enable is clear or either flag is set (any state other than `ST_RUN`).
- R7: The pending word is at offset 0x04. A write clears each bit written as zero and keeps each bit written as one, so writing zero clears all.
- R8: A channel event in the same cycle as a pending-clear write wins: the bit ends up set.
- R9: `irq` is high exactly when the enable is set and at least one pending bit is set.
- R10: The programmable mask at offset 0x1C is read/write and drives `chan_prog`.
- R11: Addresses with the top address bit clear form the channel space. Bits [AW-2:5] give the channel index and bits [4:0] the offset.
  - For an index below NCH, a read or write access raises that one bit of `ch_sel`, drives `ch_off`, and returns that channel's `ch_rdata` slice.
  - For an index of NCH or above, no select is raised and the read returns zero.
  - With no access, `ch_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address; top bit selects the global region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ch_sel | output | NCH | One-hot channel window select |
| ch_off | output | 5 | Byte offset inside the channel window |
| ch_rdata | input | NCH*32 | Read data from each channel's register file |
| ev_done | input | NCH | Per-channel completion event |
| ev_halt | input | NCH | Per-channel halt event |
| ev_aerr | input | NCH | Per-channel bus-fault event |
| fetch_start | output | NCH | One-cycle descriptor-fetch start pulses |
| chan_prog | output | NCH | Programmable-channel mask |
| fast_mode | output | 1 | Fast-mode enable |
| irq | output | 1 | Combined interrupt |

## Verification
The following relations are checked on every cycle:
- Every event leaves its pending bit set on the next cycle, whether or not a clear write coincided with it.
- A halt event always raises the halt flag.
- `irq` always equals enable-and-any-pending.
- A start pulse only ever follows a doorbell write made in `ST_RUN`.
- `ch_sel` is never more than one-hot.

The bench's scenarios cover the rest:
- Software cannot set the flags.
- Flags clear selectively by bit.
- The pending word keeps bits written as one.
- The in-flight word tracks starts and events.
- Doorbells stop working while stalled and start again after recovery.
- Channel-window reads decode correctly, including indices beyond the channel count.

// File: rtl/dmag_pkg.sv
`timescale 1ns/1ps
package dmag_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } ctl_state_e;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_PEND  = 'h04;
    localparam int OFF_DB    = 'h08;
    localparam int OFF_DBSET = 'h0C;
    localparam int OFF_PROG  = 'h1C;

    localparam int BIT_EN   = 0;
    localparam int BIT_AERR = 2;
    localparam int BIT_HALT = 3;
    localparam int BIT_FAST = 31;

    localparam int WIN_LG = 5;
endpackage

// File: rtl/dmag_decode.sv
`timescale 1ns/1ps
module dmag_decode #(
    parameter int AW  = 13,
    parameter int NCH = 6
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [AW-1:0]        bus_addr,
    output logic                 hit_ctrl,
    output logic                 hit_pend,
    output logic                 hit_db,
    output logic                 hit_dbset,
    output logic                 hit_prog,
    output logic                 ch_hit,
    output logic [AW-2-dmag_pkg::WIN_LG:0] ch_idx,
    output logic [NCH-1:0]       ch_sel,
    output logic [dmag_pkg::WIN_LG-1:0] ch_off
);
    import dmag_pkg::*;
    localparam int GW   = AW - 1;
    localparam int IDXW = AW - 1 - WIN_LG;

    logic          glb;
    logic [GW-1:0] goff;

    assign glb  = bus_addr[AW-1];
    assign goff = bus_addr[GW-1:0];

    assign hit_ctrl  = glb && (goff == GW'(OFF_CTRL));
    assign hit_pend  = glb && (goff == GW'(OFF_PEND));
    assign hit_db    = glb && (goff == GW'(OFF_DB));
    assign hit_dbset = glb && (goff == GW'(OFF_DBSET));
    assign hit_prog  = glb && (goff == GW'(OFF_PROG));

    assign ch_idx = bus_addr[AW-2:WIN_LG];
    assign ch_off = bus_addr[WIN_LG-1:0];
    assign ch_hit = !glb && (ch_idx < IDXW'(NCH));

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign ch_sel[g] = (bus_wr || bus_rd) && ch_hit && (ch_idx == IDXW'(g));
    end
endmodule

// File: rtl/dmag_fsm.sv
`timescale 1ns/1ps
module dmag_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic                  wr_en,
    input  logic                  wr_halt,
    input  logic                  wr_aerr,
    input  logic                  halt_ev,
    input  logic                  aerr_ev,
    output dmag_pkg::ctl_state_e  st,
    output logic                  halt_q,
    output logic                  aerr_q,
    output logic                  enabled,
    output logic                  run_ok
);
    import dmag_pkg::*;

    ctl_state_e st_nxt;
    logic       en_nxt;
    logic       halt_nxt;
    logic       aerr_nxt;
    logic       fault_nxt;

    // next-state process
    always_comb begin
        en_nxt    = (st != ST_OFF);
        if (ctrl_we) en_nxt = wr_en;
        halt_nxt  = halt_ev | (halt_q & ~(ctrl_we & ~wr_halt));
        aerr_nxt  = aerr_ev | (aerr_q & ~(ctrl_we & ~wr_aerr));
        fault_nxt = halt_nxt | aerr_nxt;
        st_nxt    = st;
        unique case (st)
            ST_OFF: begin
                if (en_nxt) st_nxt = fault_nxt ? ST_STALL : ST_RUN;
            end
            ST_RUN: begin
                if (!en_nxt)        st_nxt = ST_OFF;
                else if (fault_nxt) st_nxt = ST_STALL;
            end
            ST_STALL: begin
                if (!en_nxt)         st_nxt = ST_OFF;
                else if (!fault_nxt) st_nxt = ST_RUN;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            halt_q <= 1'b0;
            aerr_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            halt_q <= halt_nxt;
            aerr_q <= aerr_nxt;
        end
    end

    // outputs
    always_comb begin
        enabled = 1'b0;
        run_ok  = 1'b0;
        unique case (st)
            ST_OFF:   ;
            ST_RUN:   begin enabled = 1'b1; run_ok = 1'b1; end
            ST_STALL: enabled = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/dmag_chan_track.sv
`timescale 1ns/1ps
module dmag_chan_track #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_done,
    input  logic [NCH-1:0] ev_halt,
    input  logic [NCH-1:0] ev_aerr,
    input  logic           pend_we,
    input  logic [NCH-1:0] pend_keep,
    input  logic [NCH-1:0] db_go,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] active_q,
    output logic [NCH-1:0] start_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ev;
        logic p_r;
        logic a_r;
        logic s_r;
        assign ev = ev_done[g] | ev_halt[g] | ev_aerr[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_r <= 1'b0;
                a_r <= 1'b0;
                s_r <= 1'b0;
            end else begin
                p_r <= ev | (p_r & ~(pend_we & ~pend_keep[g]));
                a_r <= db_go[g] | (a_r & ~ev);
                s_r <= db_go[g];
            end
        end
        assign pend_q[g]   = p_r;
        assign active_q[g] = a_r;
        assign start_q[g]  = s_r;
    end
endmodule

// File: rtl/dma_glb_ctrl.sv
`timescale 1ns/1ps
module dma_glb_ctrl #(
    parameter int NCH = 6,
    parameter int AW  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    ch_sel,
    output logic [4:0]        ch_off,
    input  logic [NCH*32-1:0] ch_rdata,
    input  logic [NCH-1:0]    ev_done,
    input  logic [NCH-1:0]    ev_halt,
    input  logic [NCH-1:0]    ev_aerr,
    output logic [NCH-1:0]    fetch_start,
    output logic [NCH-1:0]    chan_prog,
    output logic              fast_mode,
    output logic              irq
);
    import dmag_pkg::*;
    localparam int IDXW = AW - 1 - WIN_LG;

    logic hit_ctrl, hit_pend, hit_db, hit_dbset, hit_prog, ch_hit;
    logic [IDXW-1:0] ch_idx;
    ctl_state_e st;
    logic halt_q, aerr_q, enabled, run_ok;
    logic ctrl_we;
    logic [NCH-1:0] pend_q, active_q, db_go;
    logic fast_q;
    logic [NCH-1:0] prog_q;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    dmag_decode #(.AW(AW), .NCH(NCH)) u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .hit_ctrl(hit_ctrl), .hit_pend(hit_pend), .hit_db(hit_db),
        .hit_dbset(hit_dbset), .hit_prog(hit_prog),
        .ch_hit(ch_hit), .ch_idx(ch_idx), .ch_sel(ch_sel), .ch_off(ch_off)
    );

    assign ctrl_we = bus_wr && hit_ctrl;

    dmag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .wr_en(bus_wdata[BIT_EN]), .wr_halt(bus_wdata[BIT_HALT]),
        .wr_aerr(bus_wdata[BIT_AERR]),
        .halt_ev(|ev_halt), .aerr_ev(|ev_aerr),
        .st(st), .halt_q(halt_q), .aerr_q(aerr_q),
        .enabled(enabled), .run_ok(run_ok)
    );

    assign db_go = (bus_wr && hit_dbset && run_ok) ? bus_wdata[NCH-1:0] : '0;

    dmag_chan_track #(.NCH(NCH)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev_done), .ev_halt(ev_halt), .ev_aerr(ev_aerr),
        .pend_we(bus_wr && hit_pend), .pend_keep(bus_wdata[NCH-1:0]),
        .db_go(db_go),
        .pend_q(pend_q), .active_q(active_q), .start_q(fetch_start)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            prog_q <= '0;
        end else begin
            if (ctrl_we)             fast_q <= bus_wdata[BIT_FAST];
            if (bus_wr && hit_prog)  prog_q <= bus_wdata[NCH-1:0];
        end
    end

    assign fast_mode = fast_q;
    assign chan_prog = prog_q;
    assign irq       = enabled && (|pend_q);

    always_comb begin
        bus_rdata = '0;
        if (ch_hit) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_idx == IDXW'(i)) bus_rdata = ch_rdata[i*32 +: 32];
            end
        end else if (hit_ctrl) begin
            bus_rdata[BIT_EN]   = enabled;
            bus_rdata[BIT_AERR] = aerr_q;
            bus_rdata[BIT_HALT] = halt_q;
            bus_rdata[BIT_FAST] = fast_q;
        end else if (hit_pend) begin
            bus_rdata[NCH-1:0] = pend_q;
        end else if (hit_db) begin
            bus_rdata[NCH-1:0] = active_q;
        end else if (hit_prog) begin
            bus_rdata[NCH-1:0] = prog_q;
        end
    end
endmodule

// File: rtl/dma_glb_ctrl_chk.sv
`timescale 1ns/1ps
module dma_glb_ctrl_chk #(
    parameter int NCH = 6,
    parameter int AW  = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [NCH-1:0]       ev_done,
    input logic [NCH-1:0]       ev_halt,
    input logic [NCH-1:0]       ev_aerr,
    input logic [NCH-1:0]       fetch_start,
    input logic [NCH-1:0]       ch_sel,
    input logic                 irq,
    input dmag_pkg::ctl_state_e st,
    input logic [NCH-1:0]       pend_q,
    input logic                 halt_q
);
    import dmag_pkg::*;
    localparam logic [AW-1:0] A_DBSET = AW'((1 << (AW-1)) + OFF_DBSET);

    logic [NCH-1:0] ev_any;
    assign ev_any = ev_done | ev_halt | ev_aerr;

    p_event_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_any) |=> ((pend_q & $past(ev_any)) == $past(ev_any)));

    p_halt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_halt) |=> halt_q);

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((st != ST_OFF) && (|pend_q)));

    p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fetch_start) |-> $past(bus_wr && (bus_addr == A_DBSET)));

    p_start_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|fetch_start) |-> $past(st == ST_RUN));

    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));
endmodule

bind dma_glb_ctrl dma_glb_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .ev_done(ev_done), .ev_halt(ev_halt), .ev_aerr(ev_aerr),
    .fetch_start(fetch_start), .ch_sel(ch_sel), .irq(irq),
    .st(st), .pend_q(pend_q), .halt_q(halt_q)
);

// File: tb/dma_glb_ctrl_bench.sv
`timescale 1ns/1ps
module dma_glb_ctrl_bench;
    localparam int NCH = 6;
    localparam int AW  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] ch_sel;
    logic [4:0] ch_off;
    logic [NCH*32-1:0] ch_rdata = '0;
    logic [NCH-1:0] ev_done = '0, ev_halt = '0, ev_aerr = '0;
    logic [NCH-1:0] fetch_start, chan_prog;
    logic fast_mode, irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dma_glb_ctrl #(.NCH(NCH), .AW(AW)) u_dma_glb_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_sel(ch_sel), .ch_off(ch_off), .ch_rdata(ch_rdata),
        .ev_done(ev_done), .ev_halt(ev_halt), .ev_aerr(ev_aerr),
        .fetch_start(fetch_start), .chan_prog(chan_prog),
        .fast_mode(fast_mode), .irq(irq)
    );

    // vector: {is_read, addr[12:0], data[31:0], req[3:0]}
    localparam logic [49:0] VECS [0:9] = '{
        {1'b1, 13'h1000, 32'h0000_0000, 4'd1},  // R1 control idle
        {1'b0, 13'h1000, 32'h8000_0001, 4'd2},  // R2 enable + fast
        {1'b1, 13'h1000, 32'h8000_0001, 4'd2},  // R2
        {1'b0, 13'h1000, 32'h0000_000D, 4'd2},  // R2 flags not settable
        {1'b1, 13'h1000, 32'h0000_0001, 4'd2},  // R2
        {1'b0, 13'h101C, 32'h0000_0015, 4'd10}, // R10
        {1'b1, 13'h101C, 32'h0000_0015, 4'd10}, // R10
        {1'b1, 13'h1008, 32'h0000_0000, 4'd5},  // R5 nothing in flight
        {1'b1, 13'h100C, 32'h0000_0000, 4'd5},  // R5 set reg reads zero
        {1'b1, 13'h1004, 32'h0000_0000, 4'd7}   // R7 pending idle
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [AW-1:0] a, input logic [31:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] h, input logic [NCH-1:0] e);
        @(negedge clk);
        ev_done = d; ev_halt = h; ev_aerr = e;
        @(negedge clk);
        ev_done = '0; ev_halt = '0; ev_aerr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(1, {31'b0, irq}, 32'd0);
        chk(1, {26'b0, fetch_start}, 32'd0);
        chk(1, {26'b0, chan_prog}, 32'd0);
        chk(1, {31'b0, fast_mode}, 32'd0);

        for (int i = 0; i < 10; i++) begin
            if (VECS[i][49]) rd_chk(int'(VECS[i][3:0]), VECS[i][48:36], VECS[i][35:4]);
            else wr(VECS[i][48:36], VECS[i][35:4]);
        end
        chk(10, {26'b0, chan_prog}, 32'h15);
        chk(2, {31'b0, fast_mode}, 32'd0);

        // R5 doorbell start pulse and in-flight tracking
        wr(13'h100C, 32'h05);
        chk(5, {26'b0, fetch_start}, 32'h05);
        @(negedge clk);
        chk(5, {26'b0, fetch_start}, 32'h00);
        rd_chk(5, 13'h1008, 32'h05);

        // R3 done event: pending only; R9 irq
        pulse(6'h01, 6'h00, 6'h00);
        rd_chk(3, 13'h1004, 32'h01);
        chk(9, {31'b0, irq}, 32'd1);
        rd_chk(3, 13'h1008, 32'h04);
        rd_chk(3, 13'h1000, 32'h01);

        // R7 write-zero clears, write-one keeps
        wr(13'h1004, 32'h3E);
        rd_chk(7, 13'h1004, 32'h00);
        chk(9, {31'b0, irq}, 32'd0);
        pulse(6'h06, 6'h00, 6'h00);
        wr(13'h1004, 32'h02);
        rd_chk(7, 13'h1004, 32'h02);
        wr(13'h1004, 32'h00);
        rd_chk(7, 13'h1004, 32'h00);

        // R8 event coincident with clear wins
        @(negedge clk);
        ev_done = 6'h08; bus_wr = 1'b1; bus_addr = 13'h1004; bus_wdata = 32'h0;
        @(negedge clk);
        ev_done = '0; bus_wr = 1'b0;
        rd_chk(8, 13'h1004, 32'h08);

        // R9 irq gated by enable
        wr(13'h1000, 32'h0);
        chk(9, {31'b0, irq}, 32'd0);
        wr(13'h1000, 32'h1);
        chk(9, {31'b0, irq}, 32'd1);
        wr(13'h1004, 32'h0);

        // R3 halt event
        pulse(6'h00, 6'h04, 6'h00);
        rd_chk(3, 13'h1000, 32'h09);
        rd_chk(3, 13'h1004, 32'h04);
        rd_chk(3, 13'h1008, 32'h00);

        // R6 doorbell ignored while stalled
        wr(13'h100C, 32'h01);
        chk(6, {26'b0, fetch_start}, 32'h00);
        @(negedge clk);
        chk(6, {26'b0, fetch_start}, 32'h00);
        rd_chk(6, 13'h1008, 32'h00);

        // R3 bus-fault event
        pulse(6'h00, 6'h00, 6'h10);
        rd_chk(3, 13'h1000, 32'h0D);
        rd_chk(3, 13'h1004, 32'h14);

        // R4 selective flag clear
        wr(13'h1000, 32'h09);
        rd_chk(4, 13'h1000, 32'h09);
        wr(13'h1000, 32'h01);
        rd_chk(4, 13'h1000, 32'h01);
        wr(13'h100C, 32'h02);
        chk(6, {26'b0, fetch_start}, 32'h02);

        // R6 doorbell ignored while disabled
        wr(13'h1000, 32'h0);
        wr(13'h100C, 32'h01);
        chk(6, {26'b0, fetch_start}, 32'h00);
        rd_chk(6, 13'h1008, 32'h02);

        // R11 channel window decode
        for (int i = 0; i < NCH; i++) ch_rdata[i*32 +: 32] = 32'hC0DE_0000 | i;
        bus_addr = 13'h006C; bus_rd = 1'b1;
        #1;
        chk(11, {26'b0, ch_sel}, 32'h08);
        chk(11, {27'b0, ch_off}, 32'h0C);
        chk(11, bus_rdata, 32'hC0DE_0003);
        bus_addr = 13'h00C4;
        #1;
        chk(11, {26'b0, ch_sel}, 32'h00);
        chk(11, bus_rdata, 32'h0);
        bus_addr = 13'h006C; bus_rd = 1'b0;
        #1;
        chk(11, {26'b0, ch_sel}, 32'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule